// File: doc/BRIEF.md
# Test Pattern Pixel Generator

This block produces a complete 640x480, 60 Hz video raster and works out the 12-bit colour of every pixel from the current horizontal and vertical position alone. No image is stored anywhere. The only state is the position counters and two small counters that track the position within the grid. The picture is a backdrop of white grid lines at a 36-pixel pitch on a dark grey field. A central figure sits on top of it, and the inside of the figure is painted as twelve horizontal colour bands. The band for each row is picked by comparing the row number against fixed limits.

A mode input chooses the shape of the figure. In rectangle mode the whole bounding box of the figure is filled. In circle mode a pixel in the box is filled only when an external circle tester raises its inside flag for the current pixel. Pixels the tester rejects show the backdrop. The block runs on a 25 MHz pixel clock. The colour outputs are combinational from the registered position, so a colour is valid in the same cycle as the coordinate that produced it.

Top module: `testcard_gen`

## Requirements
- R1: After reset the raster position is column 0 of row 0. The column advances by one each clock through 800 columns (0 to 799). When the column wraps, the row advances, through 525 rows (0 to 524), then both wrap to zero. During reset the outputs show pixel (0,0): both syncs high and colour 0xFFF.
- R2: hsync_n is low exactly while the column is in 656..751. vsync_n is low exactly while the row is in 490..491. Both are high at all other times.
- R3: Outside the filled figure, a visible pixel whose column or row is a multiple of 36 is white, with red, green and blue all at 0xF.
- R4: When mode_circle is 0, every visible pixel in columns 140..499 and rows 60..419 shows its band colour, whatever the value of circle_in.
- R5: When mode_circle is 1, a pixel inside that box shows its band colour only if circle_in is 1. If circle_in is 0, the pixel shows the grid or background colour that R3 and R7 give.
- R6: When the column is 640 or more or the row is 480 or more, red, green and blue are all 0.
- R7: Any other visible pixel, off the grid lines and outside the filled figure, is background grey, with red, green and blue all at 0x3.
- R8: The filled figure has 12 bands, each 30 rows tall. The band index is b = (row - 60) / 30. Its colour is red = b, green = 11 - b, and blue = 0xF when b is odd and 0x0 when b is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (25 MHz at the default timing) |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_circle | input | 1 | 0 selects the rectangular figure, 1 the circular figure |
| circle_in | input | 1 | Inside flag for the current pixel, from the external circle tester |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 4 | Red intensity |
| grn | output | 4 | Green intensity |
| blu | output | 4 | Blue intensity |

## Verification
The bench runs the generator with a reduced geometry so that several whole frames fit in the run, and compares every pixel against a model of that geometry. In the first frame the rectangle mode is used while circle_in toggles at random, which shows that the flag has no effect there. In the second frame circle mode is used with the flag held low, which must expose the grid and background across the whole box. In the third frame both inputs are random per pixel, which separates the band colours from the backdrop pixel by pixel. A reset in the middle of a frame then shows that the raster restarts from the origin.

// File: rtl/tc_pkg.sv
package tc_pkg;

    localparam int NBAND = 12;

    localparam logic [11:0] LINE_RGB = 12'hFFF;
    localparam logic [11:0] BACK_RGB = 12'h333;

    // Colour of interior band b: {red, green, blue}
    function automatic logic [11:0] band_rgb(input logic [3:0] b);
        logic [3:0] g;
        g = 4'(NBAND - 1) - b;
        return {b, g, (b[0] ? 4'hF : 4'h0)};
    endfunction

endpackage

// File: rtl/tc_raster.sv
module tc_raster #(
    parameter int H_ACT = 640,
    parameter int H_FP  = 16,
    parameter int H_SW  = 96,
    parameter int H_BP  = 48,
    parameter int V_ACT = 480,
    parameter int V_FP  = 10,
    parameter int V_SW  = 2,
    parameter int V_BP  = 33,
    parameter int HW    = 10,
    parameter int VW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt,
    output logic          line_end,
    output logic          frame_end,
    output logic          active,
    output logic          hsync_n,
    output logic          vsync_n
);
    localparam int HT = H_ACT + H_FP + H_SW + H_BP;
    localparam int VT = V_ACT + V_FP + V_SW + V_BP;
    localparam logic [HW-1:0] H_LAST = HW'(HT - 1);
    localparam logic [VW-1:0] V_LAST = VW'(VT - 1);
    localparam logic [HW-1:0] HS_LO  = HW'(H_ACT + H_FP);
    localparam logic [HW-1:0] HS_HI  = HW'(H_ACT + H_FP + H_SW);
    localparam logic [VW-1:0] VS_LO  = VW'(V_ACT + V_FP);
    localparam logic [VW-1:0] VS_HI  = VW'(V_ACT + V_FP + V_SW);
    localparam logic [HW-1:0] H_VIS  = HW'(H_ACT);
    localparam logic [VW-1:0] V_VIS  = VW'(V_ACT);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (pos_q.h == H_LAST) begin
            pos_d.h = '0;
            pos_d.v = (pos_q.v == V_LAST) ? '0 : pos_q.v + 1'b1;
        end else begin
            pos_d.h = pos_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign hcnt      = pos_q.h;
    assign vcnt      = pos_q.v;
    assign line_end  = (pos_q.h == H_LAST);
    assign frame_end = line_end && (pos_q.v == V_LAST);
    assign active    = (pos_q.h < H_VIS) && (pos_q.v < V_VIS);
    assign hsync_n   = !((pos_q.h >= HS_LO) && (pos_q.h < HS_HI));
    assign vsync_n   = !((pos_q.v >= VS_LO) && (pos_q.v < VS_HI));

endmodule

// File: rtl/tc_gridtrack.sv
module tc_gridtrack #(
    parameter int GRID = 36,
    parameter int GW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    input  logic          frame_end,
    output logic [GW-1:0] gx,
    output logic [GW-1:0] gy
);
    localparam logic [GW-1:0] G_LAST = GW'(GRID - 1);

    typedef struct packed {
        logic [GW-1:0] x;
        logic [GW-1:0] y;
    } phase_t;

    phase_t ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (line_end) begin
            ph_d.x = '0;
            if (frame_end)            ph_d.y = '0;
            else if (ph_q.y == G_LAST) ph_d.y = '0;
            else                       ph_d.y = ph_q.y + 1'b1;
        end else begin
            ph_d.x = (ph_q.x == G_LAST) ? '0 : ph_q.x + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign gx = ph_q.x;
    assign gy = ph_q.y;

endmodule

// File: rtl/tc_palette.sv
module tc_palette
    import tc_pkg::*;
#(
    parameter int FIG_X0 = 140,
    parameter int FIG_W  = 360,
    parameter int FIG_Y0 = 60,
    parameter int FIG_H  = 360,
    parameter int HW     = 10,
    parameter int VW     = 10,
    parameter int GW     = 6
) (
    input  logic [HW-1:0] hcnt,
    input  logic [VW-1:0] vcnt,
    input  logic [GW-1:0] gx,
    input  logic [GW-1:0] gy,
    input  logic          active,
    input  logic          mode_circle,
    input  logic          circle_in,
    output logic [11:0]   rgb
);
    localparam int BAND_H = FIG_H / NBAND;
    localparam logic [HW-1:0] BX_LO = HW'(FIG_X0);
    localparam logic [HW-1:0] BX_HI = HW'(FIG_X0 + FIG_W);
    localparam logic [VW-1:0] BY_LO = VW'(FIG_Y0);
    localparam logic [VW-1:0] BY_HI = VW'(FIG_Y0 + FIG_H);

    logic [NBAND-2:0] below;
    logic [3:0]       band;
    logic             in_box;
    logic             filled;
    logic             on_line;

    for (genvar k = 1; k < NBAND; k++) begin : g_limit
        localparam logic [VW-1:0] LIMIT = VW'(FIG_Y0 + k * BAND_H);
        assign below[k-1] = (vcnt >= LIMIT);
    end

    always_comb begin
        band    = 4'($countones(below));
        in_box  = (hcnt >= BX_LO) && (hcnt < BX_HI) &&
                  (vcnt >= BY_LO) && (vcnt < BY_HI);
        filled  = in_box && (!mode_circle || circle_in);
        on_line = (gx == '0) || (gy == '0);
        if (!active)      rgb = 12'h000;
        else if (filled)  rgb = band_rgb(band);
        else if (on_line) rgb = LINE_RGB;
        else              rgb = BACK_RGB;
    end

endmodule

// File: rtl/testcard_gen.sv
module testcard_gen #(
    parameter int H_ACT  = 640,
    parameter int H_FP   = 16,
    parameter int H_SW   = 96,
    parameter int H_BP   = 48,
    parameter int V_ACT  = 480,
    parameter int V_FP   = 10,
    parameter int V_SW   = 2,
    parameter int V_BP   = 33,
    parameter int GRID   = 36,
    parameter int FIG_X0 = 140,
    parameter int FIG_W  = 360,
    parameter int FIG_Y0 = 60,
    parameter int FIG_H  = 360
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_circle,
    input  logic       circle_in,
    output logic       hsync_n,
    output logic       vsync_n,
    output logic [3:0] red,
    output logic [3:0] grn,
    output logic [3:0] blu
);
    localparam int HT = H_ACT + H_FP + H_SW + H_BP;
    localparam int VT = V_ACT + V_FP + V_SW + V_BP;
    localparam int HW = $clog2(HT);
    localparam int VW = $clog2(VT);
    localparam int GW = $clog2(GRID);

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic [GW-1:0] gx, gy;
    logic          line_end, frame_end, active;
    logic [11:0]   rgb;

    tc_raster #(
        .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
        .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP),
        .HW(HW), .VW(VW)
    ) u_raster (
        .clk(clk), .rst_n(rst_n),
        .hcnt(hcnt), .vcnt(vcnt),
        .line_end(line_end), .frame_end(frame_end), .active(active),
        .hsync_n(hsync_n), .vsync_n(vsync_n)
    );

    tc_gridtrack #(.GRID(GRID), .GW(GW)) u_grid (
        .clk(clk), .rst_n(rst_n),
        .line_end(line_end), .frame_end(frame_end),
        .gx(gx), .gy(gy)
    );

    tc_palette #(
        .FIG_X0(FIG_X0), .FIG_W(FIG_W), .FIG_Y0(FIG_Y0), .FIG_H(FIG_H),
        .HW(HW), .VW(VW), .GW(GW)
    ) u_pal (
        .hcnt(hcnt), .vcnt(vcnt), .gx(gx), .gy(gy), .active(active),
        .mode_circle(mode_circle), .circle_in(circle_in), .rgb(rgb)
    );

    assign red = rgb[11:8];
    assign grn = rgb[7:4];
    assign blu = rgb[3:0];

endmodule

// File: rtl/testcard_gen_chk.sv
module testcard_gen_chk #(
    parameter int H_ACT  = 640,
    parameter int H_FP   = 16,
    parameter int V_ACT  = 480,
    parameter int V_FP   = 10,
    parameter int HT     = 800,
    parameter int GRID   = 36,
    parameter int FIG_X0 = 140,
    parameter int HW     = 10,
    parameter int VW     = 10,
    parameter int GW     = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [HW-1:0] hcnt,
    input logic [VW-1:0] vcnt,
    input logic [GW-1:0] gx,
    input logic [GW-1:0] gy,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic [3:0]    red,
    input logic [3:0]    grn,
    input logic [3:0]    blu
);
    assert_col_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt != HW'(HT - 1)) |=> (hcnt == $past(hcnt) + 1'b1));

    assert_hsync_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n) |-> (hcnt == HW'(H_ACT + H_FP)));

    assert_vsync_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |-> (hcnt == '0 && vcnt == VW'(V_ACT + V_FP)));

    assert_grid_white_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((hcnt < HW'(FIG_X0)) && (vcnt < VW'(V_ACT)) && (gx == '0 || gy == '0))
        |-> ({red, grn, blu} == 12'hFFF));

    assert_grid_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gx < GW'(GRID)) && (gy < GW'(GRID)));

    assert_blank_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((hcnt >= HW'(H_ACT)) || (vcnt >= VW'(V_ACT))) |-> ({red, grn, blu} == 12'h000));

endmodule

bind testcard_gen testcard_gen_chk #(
    .H_ACT(H_ACT), .H_FP(H_FP), .V_ACT(V_ACT), .V_FP(V_FP), .HT(HT),
    .GRID(GRID), .FIG_X0(FIG_X0), .HW(HW), .VW(VW), .GW(GW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .gx(gx), .gy(gy),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .red(red), .grn(grn), .blu(blu)
);

// File: tb/tb_testcard_gen.sv
module tb_testcard_gen;
    localparam int HA = 160, HF = 8, HS = 16, HB = 16;
    localparam int VA = 120, VF = 4, VS = 2, VB = 6;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int GRID = 36;
    localparam int X0 = 40, W = 72, Y0 = 12, H = 96;
    localparam int BH = H / 12;
    localparam int FRAME = HT * VT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_circle = 1'b0;
    logic circle_in = 1'b0;
    logic hsync_n, vsync_n;
    logic [3:0] red, grn, blu;

    int total = 0;
    int bad = 0;
    int bh = 0;
    int bv = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    testcard_gen #(
        .H_ACT(HA), .H_FP(HF), .H_SW(HS), .H_BP(HB),
        .V_ACT(VA), .V_FP(VF), .V_SW(VS), .V_BP(VB),
        .GRID(GRID), .FIG_X0(X0), .FIG_W(W), .FIG_Y0(Y0), .FIG_H(H)
    ) dut (
        .clk(clk), .rst_n(rst_n), .mode_circle(mode_circle), .circle_in(circle_in),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .red(red), .grn(grn), .blu(blu)
    );

    // Bench model of the raster position
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bh <= 0; bv <= 0;
        end else if (bh == HT - 1) begin
            bh <= 0;
            bv <= (bv == VT - 1) ? 0 : bv + 1;
        end else begin
            bh <= bh + 1;
        end
    end

    function automatic logic [11:0] band_exp(input int b);
        logic [3:0] r, g;
        r = 4'(b);
        g = 4'(11 - b);
        return {r, g, ((b % 2) == 1) ? 4'hF : 4'h0};
    endfunction

    function automatic bit in_box(input int x, input int y);
        return x >= X0 && x < X0 + W && y >= Y0 && y < Y0 + H;
    endfunction

    function automatic logic [11:0] pix_exp(input int x, input int y, input bit m, input bit c);
        if (!(x < HA && y < VA)) return 12'h000;
        if (in_box(x, y) && (!m || c)) return band_exp((y - Y0) / BH);
        if ((x % GRID) == 0 || (y % GRID) == 0) return 12'hFFF;
        return 12'h333;
    endfunction

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at x=%0d y=%0d: actual=%h expected=%h", tag, bh, bv, act, exp);
        end
    endtask

    task automatic check_pixel();
        logic [11:0] e;
        string tag;
        e = pix_exp(bh, bv, mode_circle, circle_in);
        if (!(bh < HA && bv < VA))                          tag = "R6 blank";
        else if (in_box(bh, bv) && mode_circle && circle_in) tag = "R5/R8 circle fill";
        else if (in_box(bh, bv) && mode_circle)              tag = "R5 circle hole";
        else if (in_box(bh, bv))                             tag = "R4/R8 rect fill";
        else if (e == 12'hFFF)                               tag = "R3 grid";
        else                                                 tag = "R7 background";
        check(tag, {red, grn, blu}, e);
        check("R2 hsync", {11'd0, hsync_n}, {11'd0, !(bh >= HA + HF && bh < HA + HF + HS)});
        check("R2 vsync", {11'd0, vsync_n}, {11'd0, !(bv >= VA + VF && bv < VA + VF + VS)});
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5544));
        // R1: reset state shows pixel (0,0)
        repeat (3) @(negedge clk);
        check("R1 reset hsync", {11'd0, hsync_n}, 12'h001);
        check("R1 reset vsync", {11'd0, vsync_n}, 12'h001);
        check("R1 reset colour", {red, grn, blu}, 12'hFFF);
        rst_n = 1'b1;

        // Frame 1: rectangle, circle_in toggling must not matter (R4)
        for (int i = 0; i < FRAME; i++) begin
            @(negedge clk);
            mode_circle = 1'b0;
            circle_in = 1'($urandom);
            #1 check_pixel();
        end
        // Frame 2: circle mode with flag low exposes the backdrop (R5)
        for (int i = 0; i < FRAME; i++) begin
            @(negedge clk);
            mode_circle = 1'b1;
            circle_in = 1'b0;
            #1 check_pixel();
        end
        // Frame 3: both inputs random per pixel (R4, R5, R8)
        for (int i = 0; i < FRAME; i++) begin
            @(negedge clk);
            mode_circle = 1'($urandom);
            circle_in = 1'($urandom);
            #1 check_pixel();
        end
        // R1: reset in mid frame returns to origin, then run on
        repeat (1234) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1 check("R1 mid reset colour", {red, grn, blu}, 12'hFFF);
        rst_n = 1'b1;
        for (int i = 0; i < 3 * HT; i++) begin
            @(negedge clk);
            mode_circle = 1'($urandom);
            circle_in = 1'($urandom);
            #1 check_pixel();
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule